// File: doc/BRIEF.md
# Keyboard scan code event decoder

This block sits behind a serial keyboard frame receiver and turns its stream of received bytes into key events. Each received byte comes with a one-cycle valid strobe. A separate error strobe marks a frame that failed to receive. A key press arrives as a single scan code. A release arrives as a break prefix byte followed by the scan code. Extended keys put an extension prefix byte in front of either form.

The decoder keeps the pending prefixes in a small state machine, so a sequence of one to three bytes yields one tagged event. Each event carries the raw code, a break flag and an extended flag, and is marked by a one-cycle strobe. The decoder does not interpret characters, so Shift and lock keys come out as ordinary codes.

A pressed flag remembers whether the last reported event was a make. With it, a repeated make of the same key is marked as auto-repeat, which lets the host tell a first press from a held-key repeat.

Top module: `kbd_event_decoder`

## Requirements
- R1: During and right after reset, `ev_valid`, `ev_code`, `ev_break`, `ev_ext`, `ev_repeat` and `key_down` are all 0, and no prefix is pending.
- R2: A non-prefix byte accepted with no prefix pending gives `ev_valid` high in the following cycle, with `ev_code` equal to that byte and both `ev_break` and `ev_ext` at 0.
- R3: The break prefix 8'hF0 produces no event by itself. The next non-prefix byte is then reported with `ev_break`=1 and `ev_ext`=0.
- R4: The extension prefix 8'hE0 produces no event by itself. The next non-prefix byte is then reported with `ev_ext`=1 and `ev_break`=0.
- R5: The sequence 8'hE0, 8'hF0, code reports code with both `ev_ext`=1 and `ev_break`=1.
- R6: An 8'hE0 received while any prefix is pending discards that prefix and leaves only the extension prefix pending. For example, F0 E0 code gives an extended make.
- R7: An 8'hF0 received while a break prefix is already pending changes nothing, and the extended flag is kept. For example, E0 F0 F0 code gives an extended break.
- R8: `ev_repeat` is 1 on a make event only when the previous event was a make with the same code and the same extended flag. It is 0 on every break event and on a first press.
- R9: `key_down` becomes 1 after a make event and 0 after a break event. It keeps its value between events.
- R10: `rx_error` clears any pending prefix. If it is high in the same cycle as `rx_valid`, the byte is dropped, no event is produced, and `key_down` and the last-code memory stay unchanged.
- R11: Bytes presented while `rx_valid` is 0 have no effect. `ev_valid` lasts exactly one cycle per event, back-to-back codes give back-to-back events, and `ev_code`, `ev_break`, `ev_ext` and `ev_repeat` hold their values between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Byte from the frame receiver |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is valid |
| rx_error | input | 1 | One-cycle strobe: the receiver dropped a frame |
| ev_valid | output | 1 | One-cycle key event strobe |
| ev_code | output | 8 | Raw scan code of the event |
| ev_break | output | 1 | 1 = release, 0 = press |
| ev_ext | output | 1 | 1 = extended key |
| ev_repeat | output | 1 | Make event that repeats the previous make |
| key_down | output | 1 | Last reported event was a make |

## Verification
Two functions can act in the same cycle: the error clear of the prefix state and the acceptance of a byte. The bench provokes this by raising `rx_error` together with `rx_valid`. It does so on prefix bytes, on codes following a pending prefix, and on codes that would otherwise count as repeats. The result is judged in the next cycle and on the next code: no event may appear, the earlier prefix must be gone, and the repeat marking must continue from the last event that was actually reported. A behavioural model compares every output on every cycle, including during a random byte stream with errors mixed in.

// File: rtl/kbd_dec_pkg.sv
package kbd_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_E0   = 2'd1,
    ST_F0   = 2'd2,
    ST_E0F0 = 2'd3
  } pfx_state_t;

  // next prefix state after an accepted byte
  function automatic pfx_state_t pfx_step(pfx_state_t s, logic is_ext, logic is_brk);
    if (is_ext)
      return ST_E0;
    if (is_brk)
      return ((s == ST_E0) || (s == ST_E0F0)) ? ST_E0F0 : ST_F0;
    return ST_IDLE;
  endfunction

  function automatic logic pfx_has_ext(pfx_state_t s);
    return (s == ST_E0) || (s == ST_E0F0);
  endfunction

  function automatic logic pfx_has_brk(pfx_state_t s);
    return (s == ST_F0) || (s == ST_E0F0);
  endfunction

endpackage

// File: rtl/kbd_pfx_fsm.sv
module kbd_pfx_fsm
  import kbd_dec_pkg::*;
#(
  parameter int          CODE_W   = 8,
  parameter logic [7:0]  EXT_CODE = 8'hE0,
  parameter logic [7:0]  BRK_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_error,
  output pfx_state_t        state,
  output logic              fire,
  output logic              fire_brk,
  output logic              fire_ext
);

  logic accept, is_ext, is_brk;

  assign accept   = in_valid && !in_error;
  assign is_ext   = (in_byte == CODE_W'(EXT_CODE));
  assign is_brk   = (in_byte == CODE_W'(BRK_CODE));
  assign fire     = accept && !is_ext && !is_brk;
  assign fire_brk = pfx_has_brk(state);
  assign fire_ext = pfx_has_ext(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= ST_IDLE;
    else if (in_error)
      state <= ST_IDLE;
    else if (in_valid)
      state <= pfx_step(state, is_ext, is_brk);
  end

  // R10
  err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_error |=> state == ST_IDLE);

  // R3
  prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (is_brk || is_ext)) |-> !fire);

  // R6
  e0_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ext) |=> state == ST_E0);

  // R5
  e0_f0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_brk && state == ST_E0) |=> state == ST_E0F0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !in_error) |=> $stable(state));

endmodule

// File: rtl/kbd_evt_out.sv
module kbd_evt_out #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  input  logic              brk,
  input  logic              ext,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code,
  output logic              ev_break,
  output logic              ev_ext,
  output logic              ev_repeat,
  output logic              key_down
);

  logic is_rep;

  // repeat: make matching the last reported make
  assign is_rep = !brk && key_down && (ev_code == code) && (ev_ext == ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid  <= 1'b0;
      ev_code   <= '0;
      ev_break  <= 1'b0;
      ev_ext    <= 1'b0;
      ev_repeat <= 1'b0;
      key_down  <= 1'b0;
    end else begin
      ev_valid <= fire;
      if (fire) begin
        ev_code   <= code;
        ev_break  <= brk;
        ev_ext    <= ext;
        ev_repeat <= is_rep;
        key_down  <= !brk;
      end
    end
  end

  // R2
  event_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ev_valid && ev_code == $past(code)));

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (!ev_valid && $stable(ev_code) && $stable(key_down)));

  // R8
  break_not_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_break) |-> !ev_repeat);

  // R9
  make_sets_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (key_down == !ev_break));

endmodule

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder
  import kbd_dec_pkg::*;
#(
  parameter int         CODE_W   = 8,
  parameter logic [7:0] EXT_CODE = 8'hE0,
  parameter logic [7:0] BRK_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              rx_error,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code,
  output logic              ev_break,
  output logic              ev_ext,
  output logic              ev_repeat,
  output logic              key_down
);

  pfx_state_t pfx_state;
  logic       key_fire, key_brk, key_ext;

  kbd_pfx_fsm #(
    .CODE_W  (CODE_W),
    .EXT_CODE(EXT_CODE),
    .BRK_CODE(BRK_CODE)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_byte (rx_byte),
    .in_valid(rx_valid),
    .in_error(rx_error),
    .state   (pfx_state),
    .fire    (key_fire),
    .fire_brk(key_brk),
    .fire_ext(key_ext)
  );

  kbd_evt_out #(.CODE_W(CODE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (key_fire),
    .code     (rx_byte),
    .brk      (key_brk),
    .ext      (key_ext),
    .ev_valid (ev_valid),
    .ev_code  (ev_code),
    .ev_break (ev_break),
    .ev_ext   (ev_ext),
    .ev_repeat(ev_repeat),
    .key_down (key_down)
  );

  // R10
  err_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !ev_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!ev_valid && !key_down && pfx_state == ST_IDLE));

endmodule

// File: tb/kbd_event_decoder_tb.sv
`timescale 1ns/1ps
module kbd_event_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_error = 1'b0;
  logic       ev_valid, ev_break, ev_ext, ev_repeat, key_down;
  logic [7:0] ev_code;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  kbd_event_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_error(rx_error), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_break(ev_break), .ev_ext(ev_ext), .ev_repeat(ev_repeat),
    .key_down(key_down)
  );

  // behavioural reference: pending flags plus last-event memory
  bit pend_e = 0, pend_f = 0;
  bit m_valid = 0, m_brk = 0, m_ext = 0, m_rep = 0, m_down = 0;
  int m_code = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend_e = 0; pend_f = 0;
      m_valid = 0; m_brk = 0; m_ext = 0; m_rep = 0; m_down = 0; m_code = 0;
    end else begin
      m_valid = 0;
      if (rx_error) begin
        pend_e = 0; pend_f = 0;
      end else if (rx_valid) begin
        if (rx_byte == 8'hE0) begin
          pend_e = 1; pend_f = 0;
        end else if (rx_byte == 8'hF0) begin
          pend_f = 1;
        end else begin
          m_rep = !pend_f && m_down && (m_code == int'(rx_byte)) && (m_ext == pend_e);
          m_valid = 1; m_brk = pend_f; m_ext = pend_e;
          m_code = int'(rx_byte); m_down = !pend_f;
          pend_e = 0; pend_f = 0;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ev_valid == m_valid, cur_req, "ev_valid", ev_valid, m_valid);
      check(int'(ev_code) == m_code, cur_req, "ev_code", ev_code, m_code);
      check({ev_break, ev_ext, ev_repeat, key_down} == {m_brk, m_ext, m_rep, m_down},
            cur_req, "flags brk/ext/rep/down",
            {ev_break, ev_ext, ev_repeat, key_down}, {m_brk, m_ext, m_rep, m_down});
    end
  end

  task automatic step(logic [7:0] b, logic v, logic e);
    @(negedge clk);
    rx_byte = b; rx_valid = v; rx_error = e;
  endtask

  task automatic send(logic [7:0] b);
    step(b, 1'b1, 1'b0);
  endtask

  // one cycle after the last byte: event must be visible
  task automatic expect_ev(logic [7:0] c, bit brk, bit ext, bit rep, string req);
    @(negedge clk);
    rx_valid = 0; rx_error = 0;
    check(ev_valid === 1'b1, req, "event strobe", ev_valid, 1);
    check(ev_code === c, req, "event code", ev_code, c);
    check({ev_break, ev_ext, ev_repeat} === {brk, ext, rep}, req, "brk/ext/rep",
          {ev_break, ev_ext, ev_repeat}, {brk, ext, rep});
  endtask

  task automatic expect_none(string req);
    @(negedge clk);
    rx_valid = 0; rx_error = 0;
    check(ev_valid === 1'b0, req, "no event", ev_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check({ev_valid, ev_break, ev_ext, ev_repeat, key_down} === 5'b0, "R1",
          "outputs in reset", {ev_valid, ev_break, ev_ext, ev_repeat, key_down}, 0);
    rst_n = 1;
    @(negedge clk);
    check(ev_code === 8'h00 && ev_valid === 1'b0, "R1", "after reset", ev_code, 0);
    send(8'h1C); expect_ev(8'h1C, 0, 0, 0, "R1");

    cur_req = "R2";
    send(8'h32); expect_ev(8'h32, 0, 0, 0, "R2");

    cur_req = "R3";
    send(8'hF0); expect_none("R3");
    send(8'h32); expect_ev(8'h32, 1, 0, 0, "R3");

    cur_req = "R4";
    send(8'hE0); expect_none("R4");
    send(8'h75); expect_ev(8'h75, 0, 1, 0, "R4");

    cur_req = "R5";
    send(8'hE0); send(8'hF0); send(8'h75); expect_ev(8'h75, 1, 1, 0, "R5");

    cur_req = "R6";
    send(8'hF0); send(8'hE0); send(8'h6B); expect_ev(8'h6B, 0, 1, 0, "R6");
    send(8'hE0); send(8'hF0); send(8'hE0); send(8'h6B); expect_ev(8'h6B, 0, 1, 1, "R6");

    cur_req = "R7";
    send(8'hE0); send(8'hF0); send(8'hF0); send(8'h6B); expect_ev(8'h6B, 1, 1, 0, "R7");
    send(8'hF0); send(8'hF0); send(8'h1C); expect_ev(8'h1C, 1, 0, 0, "R7");

    cur_req = "R8";
    send(8'h1C); expect_ev(8'h1C, 0, 0, 0, "R8");
    send(8'h1C); expect_ev(8'h1C, 0, 0, 1, "R8");
    send(8'h1C); expect_ev(8'h1C, 0, 0, 1, "R8");
    send(8'hE0); send(8'h1C); expect_ev(8'h1C, 0, 1, 0, "R8");
    send(8'h23); expect_ev(8'h23, 0, 0, 0, "R8");

    cur_req = "R9";
    check(key_down === 1'b1, "R9", "down after make", key_down, 1);
    send(8'hF0); send(8'h23); expect_ev(8'h23, 1, 0, 0, "R9");
    check(key_down === 1'b0, "R9", "up after break", key_down, 0);
    repeat (3) @(negedge clk);
    check(key_down === 1'b0, "R9", "holds between events", key_down, 0);

    cur_req = "R10";
    send(8'h2B); expect_ev(8'h2B, 0, 0, 0, "R10");
    step(8'hF0, 1, 1); expect_none("R10");           // dropped prefix
    send(8'h2B); expect_ev(8'h2B, 0, 0, 1, "R10");    // still a repeat make
    send(8'hE0); step(8'h00, 0, 1); expect_none("R10");
    send(8'h2B); expect_ev(8'h2B, 0, 0, 1, "R10");    // extended prefix cleared
    send(8'hF0); step(8'h2B, 1, 1); expect_none("R10");
    check(key_down === 1'b1, "R10", "down unchanged", key_down, 1);
    send(8'h2B); expect_ev(8'h2B, 0, 0, 1, "R10");

    cur_req = "R11";
    step(8'h44, 0, 0); step(8'hF0, 0, 0); expect_none("R11");
    check(ev_code === 8'h2B && ev_repeat === 1'b1, "R11", "fields held", ev_code, 8'h2B);
    send(8'h11); send(8'h12); send(8'h13);
    expect_ev(8'h13, 0, 0, 0, "R11");
    expect_none("R11");

    // random stream, model compares every cycle
    cur_req = "R2-model";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0] b;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    b = 8'hE0;
        2, 3:    b = 8'hF0;
        4, 5:    b = 8'h1C;
        6:       b = 8'h74;
        default: b = 8'($urandom_range(0, 255));
      endcase
      step(b, ($urandom_range(0, 3) != 0), ($urandom_range(0, 11) == 0));
    end
    step(8'h00, 0, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule